// File: doc/BRIEF.md
# Serial Divider Word Loader

This block accepts a three-wire serial programming stream (a data line, a serial clock and an enable line) and turns it into three parallel divider words: a 7-bit swallow count, a 10-bit main count and an 11-bit reference count. The serial lines are asynchronous to the system clock. They pass through two-flop synchronisers, and a falling serial clock is detected in the system clock domain, which must run at least four times faster than the serial clock. While enable is high, each detected falling serial clock edge shifts one bit into a frame register. The first bit received is the most significant bit of the swallow word. It is followed by the main word and then the reference word, each most significant bit first.

When enable falls, the block copies the frame into its holding latches and emits a one-cycle realignment pulse for the phase detector. The number of falling serial clock edges counted during the enable window decides which words change. A frame of 28 edges updates all three words. A frame of 17 to 27 edges is a quick retune: the swallow and main words change and the reference word keeps its value. A frame of fewer than 17 edges changes nothing, although it still produces the realignment pulse.

The controller has three states. `ST_IDLE` waits for enable and holds the edge count at zero. The transition idle-to-shift is taken when the synchronised enable is high. `ST_SHIFT` collects bits. The transition shift-to-commit is taken when the synchronised enable goes low. `ST_COMMIT` lasts one cycle and updates the latches. The transition commit-to-idle is unconditional.

Top module: `divprog_loader`

## Requirements
- R1: After reset the swallow, main and reference outputs are all zero and `resync_o` is low.
- R2: Bits are taken on falling edges of `ser_clk`. In a 28-edge frame, received bits 1 to 7 form `a_word_o` (the first bit received is its bit 6), bits 8 to 17 form `m_word_o` (MSB first) and bits 18 to 28 form `r_word_o` (MSB first).
- R3: A frame of 17 to 27 edges loads `a_word_o` and `m_word_o` from the first 17 bits received, whatever the frame length, and leaves `r_word_o` unchanged.
- R4: A frame of fewer than 17 edges leaves all three outputs unchanged.
- R5: The edge count saturates at 28. Bits that arrive after the 28th are ignored, so a longer frame loads the same words as its first 28 bits.
- R6: While `ser_en` is low, activity on `ser_clk` and `ser_dat` does not shift bits and does not change any output.
- R7: Every falling edge of `ser_en` produces exactly one `resync_o` pulse, one system cycle wide. The pulse appears in the same cycle as the updated words. No pulse occurs at any other time.
- R8: The edge count clears each time a new enable window opens, so the length of each frame is judged on its own edges only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; bits are taken on its falling edge |
| ser_dat | input | 1 | Serial data |
| ser_en | input | 1 | Frame enable; its falling edge commits the frame |
| a_word_o | output | 7 | Latched swallow-counter word |
| m_word_o | output | 10 | Latched main-counter word |
| r_word_o | output | 11 | Latched reference-counter word |
| resync_o | output | 1 | One-cycle phase-detector realignment pulse |

## Verification
The bench sends frames of several lengths: 28 edges, 17 edges, 23 edges, 10 edges and 32 edges. Together these separate the full update, the quick retune, the no-change case and the saturation case. It also sends a 20-edge frame directly after a full frame, which shows whether a count left over from the earlier frame leaks into the later one. Serial clock toggling with enable low shows whether gated activity reaches the latches or the pulse. Each frame uses bit patterns that differ between the three words, so a slip in bit order or position appears in the output words.

// File: rtl/divprog_pkg.sv
package divprog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ld_state_e;
endpackage

// File: rtl/divprog_sync.sv
module divprog_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] fall
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-1:0], async_in[g]};
        end
        assign level[g] = pipe[STAGES-1];
        assign fall[g]  = pipe[STAGES] & ~pipe[STAGES-1];
    end
endmodule

// File: rtl/divprog_shift.sv
module divprog_shift
    import divprog_pkg::*;
#(
    parameter int FRAME_W = 28,
    parameter int AM_W    = 17,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ld_state_e          state,
    input  logic               bit_in,
    input  logic               bit_fall,
    output logic [FRAME_W-1:0] frame,
    output logic [AM_W-1:0]    am_snap,
    output logic [CNT_W-1:0]   count
);
    logic take;
    assign take = (state == ST_SHIFT) && bit_fall && (count < CNT_W'(FRAME_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame   <= '0;
            am_snap <= '0;
            count   <= '0;
        end else if (state == ST_IDLE) begin
            count <= '0;
        end else if (take) begin
            frame <= {frame[FRAME_W-2:0], bit_in};
            count <= count + 1'b1;
            if (count == CNT_W'(AM_W - 1))
                am_snap <= {frame[AM_W-2:0], bit_in};
        end
    end

    // R5: edge count never passes the frame length
    p_count_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(FRAME_W));

    // R5: once saturated, further edges leave the frame alone
    p_frame_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && count == CNT_W'(FRAME_W)) |=> $stable(frame));

    // R6: nothing shifts outside an enable window
    p_idle_no_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(frame));

    // R8: count is zero on entering the shift state
    p_count_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (count == '0));
endmodule

// File: rtl/divprog_loader.sv
module divprog_loader
    import divprog_pkg::*;
#(
    parameter int A_W      = 7,
    parameter int M_W      = 10,
    parameter int R_W      = 11,
    parameter int SYNC_STG = 2,
    localparam int AM_W    = A_W + M_W,
    localparam int FRAME_W = AM_W + R_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_en,
    output logic [A_W-1:0] a_word_o,
    output logic [M_W-1:0] m_word_o,
    output logic [R_W-1:0] r_word_o,
    output logic           resync_o
);
    logic [2:0] s_level, s_fall;
    ld_state_e state, state_nx;
    logic [FRAME_W-1:0] frame;
    logic [AM_W-1:0]    am_snap;
    logic [CNT_W-1:0]   count;

    divprog_sync #(.WIDTH(3), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({ser_en, ser_dat, ser_clk}),
        .level(s_level), .fall(s_fall)
    );

    divprog_shift #(.FRAME_W(FRAME_W), .AM_W(AM_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .state(state),
        .bit_in(s_level[1]), .bit_fall(s_fall[0]),
        .frame(frame), .am_snap(am_snap), .count(count)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (s_level[2])  state_nx = ST_SHIFT;
            ST_SHIFT:  if (!s_level[2]) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_word_o <= '0;
            m_word_o <= '0;
            r_word_o <= '0;
            resync_o <= 1'b0;
        end else begin
            resync_o <= (state == ST_COMMIT);
            if (state == ST_COMMIT) begin
                if (count >= CNT_W'(AM_W)) begin
                    a_word_o <= am_snap[AM_W-1 -: A_W];
                    m_word_o <= am_snap[M_W-1:0];
                end
                if (count == CNT_W'(FRAME_W))
                    r_word_o <= frame[R_W-1:0];
            end
        end
    end

    // R7: pulse lasts one cycle
    p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resync_o |=> !resync_o);

    // R7: pulse only follows a commit
    p_pulse_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resync_o) |-> $past(state == ST_COMMIT));

    // R3: short frame keeps the reference word
    p_short_keeps_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && count < CNT_W'(FRAME_W)) |=> $stable(r_word_o));

    // R4: very short frame changes no word
    p_tiny_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && count < CNT_W'(AM_W))
        |=> ($stable(a_word_o) && $stable(m_word_o) && $stable(r_word_o)));
endmodule

// File: tb/tb_divprog_loader.sv
module tb_divprog_loader;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
    logic [6:0]  a_w;
    logic [9:0]  m_w;
    logic [10:0] r_w;
    logic        resync;
    int checks = 0, fails = 0, pulses = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    divprog_loader dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_en(ser_en), .a_word_o(a_w), .m_word_o(m_w), .r_word_o(r_w),
        .resync_o(resync)
    );

    always @(negedge clk) if (rst_n && resync) pulses++;

    function automatic logic [39:0] mk(logic [6:0] a, logic [9:0] m,
                                       logic [10:0] r, logic [11:0] pad);
        return {a, m, r, pad};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(logic [39:0] v, int n);
        ser_en = 1'b1;
        wait_cyc(6);
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b1;
            ser_dat = v[39-i];
            wait_cyc(4);
            ser_clk = 1'b0;
            wait_cyc(4);
        end
        ser_en = 1'b0;
        wait_cyc(12);
        @(negedge clk);
    endtask

    task automatic t_full();
        int p0 = pulses;
        send(mk(7'h55, 10'h2A7, 11'h190, 12'hF0F), 28);
        chk("R2 a", a_w, 7'h55);
        chk("R2 m", m_w, 10'h2A7);
        chk("R2 r", r_w, 11'h190);
        chk("R7 pulse count", pulses - p0, 1);
    endtask

    task automatic t_short17();
        send(mk(7'h0B, 10'h155, 11'h7FF, 12'h000), 17);
        chk("R3 a", a_w, 7'h0B);
        chk("R3 m", m_w, 10'h155);
        chk("R3 r kept", r_w, 11'h190);
    endtask

    task automatic t_short23();
        send(mk(7'h71, 10'h0C3, 11'h5AA, 12'h000), 23);
        chk("R3 a 23", a_w, 7'h71);
        chk("R3 m 23", m_w, 10'h0C3);
        chk("R3 r kept 23", r_w, 11'h190);
    endtask

    task automatic t_tiny();
        int p0 = pulses;
        send(mk(7'h22, 10'h3FF, 11'h001, 12'h000), 10);
        chk("R4 a", a_w, 7'h71);
        chk("R4 m", m_w, 10'h0C3);
        chk("R4 r", r_w, 11'h190);
        chk("R7 pulse tiny", pulses - p0, 1);
    endtask

    task automatic t_long();
        send(mk(7'h3C, 10'h111, 11'h4D2, 12'hFFF), 32);
        chk("R5 a", a_w, 7'h3C);
        chk("R5 m", m_w, 10'h111);
        chk("R5 r", r_w, 11'h4D2);
    endtask

    task automatic t_gated();
        int p0 = pulses;
        for (int i = 0; i < 12; i++) begin
            ser_clk = 1'b1; ser_dat = i[0]; wait_cyc(4);
            ser_clk = 1'b0; wait_cyc(4);
        end
        wait_cyc(8);
        @(negedge clk);
        chk("R6 a", a_w, 7'h3C);
        chk("R6 r", r_w, 11'h4D2);
        chk("R6 no pulse", pulses - p0, 0);
        send(mk(7'h12, 10'h345, 11'h000, 12'h000), 17);
        chk("R6 a after gated", a_w, 7'h12);
        chk("R6 m after gated", m_w, 10'h345);
    endtask

    task automatic t_reclear();
        send(mk(7'h7F, 10'h001, 11'h6B5, 12'h000), 28);
        chk("R8 full r", r_w, 11'h6B5);
        send(mk(7'h04, 10'h2C8, 11'h0F0, 12'h000), 20);
        chk("R8 a", a_w, 7'h04);
        chk("R8 m", m_w, 10'h2C8);
        chk("R8 r kept", r_w, 11'h6B5);
    endtask

    initial begin
        wait_cyc(4);
        @(negedge clk);
        chk("R1 a", a_w, 0);
        chk("R1 m", m_w, 0);
        chk("R1 r", r_w, 0);
        chk("R1 pulse", resync, 0);
        rst_n = 1'b1;
        wait_cyc(4);
        t_full();
        t_short17();
        t_short23();
        t_tiny();
        t_long();
        t_gated();
        t_reclear();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule